// File: doc/BRIEF.md
# Composite Video Sync Timing Generator and Field Classifier

This block is the sync timing core of a composite-video encoder. It runs in one of two roles. As the timing master it counts base-clock enables and drives negative-polarity horizontal and vertical sync for 525-line (NTSC, PAL60) or 625-line (PAL) standards, in interlaced or progressive form. It also reports which field is on air. As a slave it releases its sync outputs, watches externally supplied horizontal and vertical sync, and classifies every field as odd or even. It does this by measuring where the vertical sync falling edge lands within the horizontal line.

In master mode the reset release sets the timing origin. The first base-clock enable after reset is the first clock of line 0 of an odd field, and at that point both sync outputs are already in their low (sync) state. Changing the role, the standard or the scan type while running also returns the counters to that origin, so the generator always restarts on an odd-field boundary. The block carries no data stream. Every pin is a plain level, there is no valid/ready handshake, and nothing can be back-pressured. The base-clock enable only paces the counters. Sync inputs are expected to be synchronous to `clk`. The bench uses reduced line and frame lengths. The defaults give 858/864-clock lines and 525/625-line frames.

Top module: `vsync_timing`

## Requirements
- R1: With `master_sel` high, both output enables are high and the sync outputs carry generated timing. With `master_sel` low, both output enables are low and both sync outputs rest high.
- R2: After reset release in master mode, before any base-clock enable, `hsync_o` and `vsync_o` are low and `field_odd` is high. The counters advance only on clocks where `bclk_en` is high.
- R3: `std_sel` codes are 0 = NTSC, 1 = PAL, 2 = PAL60, and 3 behaves as NTSC. `hsync_o` falls once every `H_TOTAL_625` enabled clocks for PAL and every `H_TOTAL_525` for the others. It stays low for `HS_WIDTH` enabled clocks.
- R4: In interlaced master mode, a frame holds `LINES_525` or `LINES_625` lines, split into two fields of equal half-line count. In the odd field, `vsync_o` falls together with `hsync_o`. In the even field, it falls half a line after an `hsync_o` fall. `field_odd` is high exactly during the odd field.
- R5: `vsync_o` stays low for `VS_HALF_525` half-lines on 525-line standards (3 lines by default) and `VS_HALF_625` half-lines on PAL (2.5 lines by default).
- R6: In progressive master mode, each field lasts (lines-1)/2 whole lines, every field is odd, `vsync_o` falls together with `hsync_o`, and `field_odd` stays high.
- R7: A change of `master_sel`, `std_sel` or `interlace` returns the master counters to the origin on the next clock edge. This takes priority over `bclk_en`.
- R8: In interlaced slave mode, on each enabled clock where `vsync_i` falls, the phase is the number of enabled clocks since the last `hsync_i` fall (0 when both fall together). A phase below a quarter line, or above three quarters of a line, makes the field odd. Any other phase makes it even. `field_odd` shows the result from the next clock.
- R9: In progressive slave mode, `field_odd` is high whatever the sync inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; its release sets the master timing origin |
| bclk_en | input | 1 | Base-clock enable, one pulse per video sample period |
| master_sel | input | 1 | 1 = generate sync, 0 = accept external sync |
| std_sel | input | 2 | Standard code: 0 NTSC, 1 PAL, 2 PAL60, 3 as NTSC |
| interlace | input | 1 | 1 = interlaced, 0 = progressive |
| hsync_i | input | 1 | External horizontal sync, active low |
| vsync_i | input | 1 | External vertical sync, active low |
| hsync_o | output | 1 | Generated horizontal sync, active low |
| hsync_oe | output | 1 | Drive enable for the horizontal sync pad |
| vsync_o | output | 1 | Generated vertical sync, active low |
| vsync_oe | output | 1 | Drive enable for the vertical sync pad |
| field_odd | output | 1 | 1 = odd field, 0 = even field |

## Verification
The assertions assume the configuration pins change only at a clock edge. They do not judge a vertical sync fall that happens while `std_sel` or `interlace` is moving. They also assume the external sync inputs are already synchronous to `clk`. The bench holds to this by driving every input at the falling clock edge, changing the configuration either under reset or by a single deliberate switch, and keeping `bclk_en` high during slave trials. Each slave trial begins with both sync inputs high for several enables, so every sync fall is a clean edge.

// File: rtl/vsync_pkg.sv
package vsync_pkg;

  localparam logic [1:0] STD_NTSC  = 2'd0;
  localparam logic [1:0] STD_PAL   = 2'd1;
  localparam logic [1:0] STD_PAL60 = 2'd2;

  typedef struct packed {
    logic       master;
    logic [1:0] std;
    logic       interlace;
  } vcfg_t;

  function automatic logic std_is_625(input logic [1:0] s);
    return s == STD_PAL;
  endfunction

endpackage

// File: rtl/vst_master_gen.sv
module vst_master_gen #(
  parameter int H_TOTAL_525 = 858,
  parameter int H_TOTAL_625 = 864,
  parameter int LINES_525   = 525,
  parameter int LINES_625   = 625,
  parameter int HS_WIDTH    = 64,
  parameter int VS_HALF_525 = 6,
  parameter int VS_HALF_625 = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_en,
  input  logic run,
  input  logic restart,
  input  logic is625,
  input  logic interlace,
  output logic hs_n,
  output logic vs_n,
  output logic odd
);
  localparam int H_MAX  = (H_TOTAL_625 > H_TOTAL_525) ? H_TOTAL_625 : H_TOTAL_525;
  localparam int L_MAX  = (LINES_625 > LINES_525) ? LINES_625 : LINES_525;
  localparam int HALF_W = $clog2(H_MAX / 2 + 1);
  localparam int HL_W   = $clog2(2 * L_MAX + 1);

  logic [HALF_W-1:0] hc, half_len;
  logic [HL_W-1:0]   hl, nl, wrap, vsh, fhl;
  logic              in_second;

  assign half_len = is625 ? HALF_W'(H_TOTAL_625 / 2) : HALF_W'(H_TOTAL_525 / 2);
  assign nl       = is625 ? HL_W'(LINES_625) : HL_W'(LINES_525);
  assign vsh      = is625 ? HL_W'(VS_HALF_625) : HL_W'(VS_HALF_525);
  // interlaced: the frame is 2*lines half-lines; progressive: a field of whole lines
  assign wrap     = interlace ? (nl << 1) : (nl - HL_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= '0;
      hl <= '0;
    end else if (!run || restart) begin
      hc <= '0;
      hl <= '0;
    end else if (bclk_en) begin
      if (hc >= half_len - HALF_W'(1)) begin
        hc <= '0;
        hl <= (hl >= wrap - HL_W'(1)) ? '0 : hl + HL_W'(1);
      end else begin
        hc <= hc + HALF_W'(1);
      end
    end
  end

  assign in_second = interlace & (hl >= nl);
  assign fhl       = in_second ? hl - nl : hl;
  assign hs_n      = ~(~hl[0] & (hc < HALF_W'(HS_WIDTH)));
  assign vs_n      = ~(fhl < vsh);
  assign odd       = ~in_second;

endmodule

// File: rtl/vst_field_detect.sv
module vst_field_detect #(
  parameter int H_TOTAL_525 = 858,
  parameter int H_TOTAL_625 = 864
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_en,
  input  logic run,
  input  logic is625,
  input  logic interlace,
  input  logic hs_i,
  input  logic vs_i,
  output logic odd
);
  localparam int H_MAX = (H_TOTAL_625 > H_TOTAL_525) ? H_TOTAL_625 : H_TOTAL_525;
  localparam int PW    = $clog2(H_MAX + 1);

  logic          hs_q, vs_q, odd_r, hs_fall, vs_fall, near_edge;
  logic [PW-1:0] hpos, phase, line_len, quarter;

  assign hs_fall  = hs_q & ~hs_i;
  assign vs_fall  = vs_q & ~vs_i;
  assign line_len = is625 ? PW'(H_TOTAL_625) : PW'(H_TOTAL_525);
  assign quarter  = line_len >> 2;
  assign phase    = hs_fall ? '0 : ((&hpos) ? hpos : hpos + PW'(1));
  assign near_edge = (phase < quarter) | (phase > line_len - quarter);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 1'b1;
      vs_q  <= 1'b1;
      hpos  <= '0;
      odd_r <= 1'b1;
    end else if (run && bclk_en) begin
      hs_q <= hs_i;
      vs_q <= vs_i;
      hpos <= phase;
      if (vs_fall) odd_r <= near_edge;
    end
  end

  assign odd = interlace ? odd_r : 1'b1;

endmodule

// File: rtl/vsync_timing.sv
module vsync_timing
  import vsync_pkg::*;
#(
  parameter int H_TOTAL_525 = 858,
  parameter int H_TOTAL_625 = 864,
  parameter int LINES_525   = 525,
  parameter int LINES_625   = 625,
  parameter int HS_WIDTH    = 64,
  parameter int VS_HALF_525 = 6,
  parameter int VS_HALF_625 = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bclk_en,
  input  logic       master_sel,
  input  logic [1:0] std_sel,
  input  logic       interlace,
  input  logic       hsync_i,
  input  logic       vsync_i,
  output logic       hsync_o,
  output logic       hsync_oe,
  output logic       vsync_o,
  output logic       vsync_oe,
  output logic       field_odd
);
  vcfg_t cfg_now, cfg_q;
  logic  is625, restart, gen_hs_n, gen_vs_n, gen_odd, det_odd;

  assign cfg_now = '{master: master_sel, std: std_sel, interlace: interlace};
  assign is625   = std_is_625(std_sel);

  // configuration tracker runs through reset so the first edge after release is clean
  always_ff @(posedge clk) cfg_q <= cfg_now;
  assign restart = (cfg_now != cfg_q);

  vst_master_gen #(
    .H_TOTAL_525(H_TOTAL_525), .H_TOTAL_625(H_TOTAL_625),
    .LINES_525(LINES_525), .LINES_625(LINES_625),
    .HS_WIDTH(HS_WIDTH), .VS_HALF_525(VS_HALF_525), .VS_HALF_625(VS_HALF_625)
  ) u_gen (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .run(master_sel),
    .restart(restart), .is625(is625), .interlace(interlace),
    .hs_n(gen_hs_n), .vs_n(gen_vs_n), .odd(gen_odd)
  );

  vst_field_detect #(
    .H_TOTAL_525(H_TOTAL_525), .H_TOTAL_625(H_TOTAL_625)
  ) u_det (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .run(~master_sel),
    .is625(is625), .interlace(interlace), .hs_i(hsync_i), .vs_i(vsync_i),
    .odd(det_odd)
  );

  assign hsync_oe  = master_sel;
  assign vsync_oe  = master_sel;
  assign hsync_o   = master_sel ? gen_hs_n : 1'b1;
  assign vsync_o   = master_sel ? gen_vs_n : 1'b1;
  assign field_odd = master_sel ? gen_odd : det_odd;

endmodule

// File: rtl/vsync_timing_chk.sv
module vsync_timing_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bclk_en,
  input logic       master_sel,
  input logic [1:0] std_sel,
  input logic       interlace,
  input logic       vsync_i,
  input logic       hsync_o,
  input logic       hsync_oe,
  input logic       vsync_o,
  input logic       vsync_oe,
  input logic       field_odd
);
  p_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !master_sel |-> (hsync_o && vsync_o && !hsync_oe && !vsync_oe));

  p_odd_coincide_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && $past(master_sel) && $stable(std_sel) && $stable(interlace)
     && $fell(vsync_o) && field_odd) |-> !hsync_o);

  p_even_midline_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && $past(master_sel) && $stable(std_sel) && $stable(interlace)
     && $fell(vsync_o) && !field_odd) |-> hsync_o);

  p_prog_odd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && !interlace) |-> field_odd);

  p_field_at_vs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_sel && $past(!master_sel) && $stable(interlace) && !$stable(field_odd))
    |-> (!$past(vsync_i) && $past(bclk_en)));

  p_slave_prog_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_sel && !interlace) |-> field_odd);
endmodule

bind vsync_timing vsync_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .master_sel(master_sel),
  .std_sel(std_sel), .interlace(interlace), .vsync_i(vsync_i),
  .hsync_o(hsync_o), .hsync_oe(hsync_oe), .vsync_o(vsync_o),
  .vsync_oe(vsync_oe), .field_odd(field_odd)
);

// File: tb/vsync_timing_bench.sv
module vsync_timing_bench;
  localparam int H5 = 20, H6 = 24, L5 = 11, L6 = 13, HSW = 3, V5 = 6, V6 = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0, bclk_en = 1'b0, master_sel = 1'b1, interlace = 1'b1;
  logic [1:0] std_sel = 2'd0;
  logic       hsync_i = 1'b1, vsync_i = 1'b1;
  logic       hsync_o, hsync_oe, vsync_o, vsync_oe, field_odd;

  int    n_chk = 0, n_fail = 0;
  longint k = 0;
  bit    done = 1'b0;

  vsync_timing #(
    .H_TOTAL_525(H5), .H_TOTAL_625(H6), .LINES_525(L5), .LINES_625(L6),
    .HS_WIDTH(HSW), .VS_HALF_525(V5), .VS_HALF_625(V6)
  ) u_vsync_timing (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .master_sel(master_sel),
    .std_sel(std_sel), .interlace(interlace), .hsync_i(hsync_i), .vsync_i(vsync_i),
    .hsync_o(hsync_o), .hsync_oe(hsync_oe), .vsync_o(vsync_o), .vsync_oe(vsync_oe),
    .field_odd(field_odd)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // expected {hsync, vsync, odd} after kk enabled clocks from the origin
  function automatic logic [2:0] exp_master(input logic [1:0] s, input logic il, input longint kk);
    longint hlen, nlines, half, hli, hc, hl, fhl, vsh;
    logic odd;
    hlen = (s == 2'd1) ? H6 : H5;
    nlines = (s == 2'd1) ? L6 : L5;
    vsh = (s == 2'd1) ? V6 : V5;
    half = hlen / 2;
    hli = kk / half;
    hc = kk % half;
    if (il) begin
      hl = hli % (2 * nlines);
      odd = (hl < nlines);
      fhl = odd ? hl : hl - nlines;
    end else begin
      hl = hli % (nlines - 1);
      odd = 1'b1;
      fhl = hl;
    end
    return {!((hl % 2 == 0) && (hc < HSW)), !(fhl < vsh), odd};
  endfunction

  function automatic logic exp_slave_odd(input logic [1:0] s, input logic il, input int off);
    int len, q;
    len = (s == 2'd1) ? H6 : H5;
    q = len / 4;
    if (!il) return 1'b1;
    return (off < q) || (off > len - q);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bclk_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    k = 0;
  endtask

  task automatic run_master(input int cycles);
    logic [2:0] e;
    for (int i = 0; i < cycles; i++) begin
      e = exp_master(std_sel, interlace, k);
      check("R3 hsync", hsync_o, e[2]);
      check("R5 vsync", vsync_o, e[1]);
      check(interlace ? "R4 field" : "R6 field", field_odd, e[0]);
      bclk_en = ($urandom % 5) < 3;
      @(posedge clk);
      if (bclk_en) k++;
      @(negedge clk);
    end
  endtask

  task automatic change_cfg(input logic [1:0] s, input logic il);
    std_sel = s;
    interlace = il;
    bclk_en = 1'b1;
    @(posedge clk);
    k = 0;
    @(negedge clk);
    check("R7 hsync at origin", hsync_o, 1'b0);
    check("R7 vsync at origin", vsync_o, 1'b0);
    check("R7 field at origin", field_odd, 1'b1);
  endtask

  task automatic slave_trial(input int off, input string req);
    logic e;
    e = exp_slave_odd(std_sel, interlace, off);
    bclk_en = 1'b1;
    for (int t = -4; t <= off + 3; t++) begin
      hsync_i = !(t >= 0 && t < 3);
      vsync_i = !(t >= off);
      @(posedge clk);
      @(negedge clk);
    end
    check(req, field_odd, e);
    hsync_i = 1'b1;
    vsync_i = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5EED_0017));
    do_reset();
    // R2: origin state right after release, no enable yet
    check("R2 hsync", hsync_o, 1'b0);
    check("R2 vsync", vsync_o, 1'b0);
    check("R2 field", field_odd, 1'b1);
    check("R1 hsync_oe", hsync_oe, 1'b1);
    check("R1 vsync_oe", vsync_oe, 1'b1);
    repeat (3) @(negedge clk);
    check("R2 hold without enable", hsync_o, 1'b0);

    for (int s = 0; s < 3; s++) begin
      for (int il = 1; il >= 0; il--) begin
        @(negedge clk);
        std_sel = 2'(s);
        interlace = il[0];
        do_reset();
        run_master(1400);
      end
    end

    // R7: switch standard and scan without reset
    run_master(137);
    change_cfg(2'd1, 1'b1);
    run_master(500);
    change_cfg(2'd3, 1'b1);
    run_master(300);

    // slave role
    master_sel = 1'b0;
    std_sel = 2'd0;
    interlace = 1'b1;
    bclk_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 slave hsync_oe", hsync_oe, 1'b0);
    check("R1 slave vsync_oe", vsync_oe, 1'b0);
    check("R1 slave hsync_o", hsync_o, 1'b1);
    check("R1 slave vsync_o", vsync_o, 1'b1);

    slave_trial(H5 / 2, "R8 mid-line even");
    slave_trial(0, "R8 coincident odd");
    slave_trial(4, "R8 just below quarter odd");
    slave_trial(5, "R8 at quarter even");
    slave_trial(15, "R8 at three quarters even");
    slave_trial(16, "R8 past three quarters odd");
    std_sel = 2'd1;
    slave_trial(H6 / 2, "R8 PAL mid-line even");
    slave_trial(5, "R8 PAL odd");
    slave_trial(6, "R8 PAL even");
    for (int i = 0; i < 24; i++) begin
      std_sel = ($urandom % 2 == 0) ? 2'd1 : 2'd2;
      slave_trial(int'($urandom % ((std_sel == 2'd1) ? H6 : H5)), "R8 random phase");
    end
    std_sel = 2'd0;
    interlace = 1'b0;
    slave_trial(H5 / 2, "R9 progressive mid-line stays odd");
    slave_trial(7, "R9 progressive stays odd");
    master_sel = 1'b1;
    interlace = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule